// File: doc/BRIEF.md
# AES Round Datapath

This block carries out a single AES round step on a 128-bit state, in the way a processor crypto instruction unit does. A 3-bit operation code selects one of five operations. Four are cipher rounds: a full or final encrypt round and a full or final decrypt round. The fifth is an inverse column mix on its own, used to prepare round keys for the equivalent inverse cipher. All five share one combinational datapath, and a single result register follows it.

The caller supplies a state operand, a round-key operand and an input strobe. The result and its strobe appear on the clock edge after the strobe. Bytes are numbered little-endian: byte n occupies bits 8n+7:8n, and bytes 4c through 4c+3 form column c. A complete block cipher run is built by the caller from a chain of these operations. Key expansion, instruction decode and round sequencing stay outside the block.

Top module: `aes_rnd_unit`

## Requirements
- R1: `valid_o` is high in the cycle after a cycle with `valid_i` high, and low after any cycle with `valid_i` low.
- R2: When `valid_i` is low, `result_o` holds its value, whatever `op_i`, `state_i` and `key_i` carry.
- R3: Op code 0 (full encrypt) gives MixFwd(SubFwd(ShiftFwd(state))) XOR key.
- R4: Op code 1 (final encrypt) gives SubFwd(ShiftFwd(state)) XOR key.
- R5: Op code 2 (full decrypt) gives MixInv(SubInv(ShiftInv(state))) XOR key.
- R6: Op code 3 (final decrypt) gives SubInv(ShiftInv(state)) XOR key.
- R7: Op code 4 (inverse mix only) gives MixInv(key). `state_i` is ignored, and no substitution, row shift or key XOR is applied. Column (8e,4d,a1,bc) becomes (db,13,53,45).
- R8: Row shifting sets output byte i to input byte (i + 4*(i mod 4)) mod 16 in the forward direction, and to input byte (i − 4*(i mod 4)) mod 16 in the inverse direction.
- R9: The forward S-box maps 00→63, 01→7c and 53→ed. The inverse S-box maps 63→00 and 00→52. Each is the exact inverse of the other over all 256 values.
- R10: Column mixing uses GF(2^8) with reduction polynomial 0x11b. Output byte j of a column is the XOR over k of M[(k−j) mod 4]·in[k], with M = {2,3,1,1} for the forward mix and {14,11,13,9} for the inverse mix.
- R11: Op codes 5 to 7 give an all-zero result, with `valid_o` behaving as in R1.
- R12: While `rst_ni` is low, `valid_o` is low and `result_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands and op code are valid this cycle |
| op_i | input | 3 | Operation select (0..4, see R3–R7) |
| state_i | input | 128 | State operand, byte n at bits 8n+7:8n |
| key_i | input | 128 | Round-key operand; the source operand for op 4 |
| valid_o | output | 1 | Result valid |
| result_o | output | 128 | Round result |

## Verification
The hardest behaviour to reach from the ports is the exact inverse relation between the two S-boxes over all 256 byte values. Each round op folds the substitution into a permutation, a mix and a key XOR. The stimulus isolates it by applying a final encrypt round with a zero key to a state whose 16 bytes are equal, which makes the row shift invisible. It then feeds that result into a final decrypt round with a zero key, sweeping all 256 values and comparing against a table the bench builds by brute-force field inversion. The column-mix ordering and the role of the operation that prepares the decrypt keys are reached only through long chains. A full 10-round encryption and an equivalent-inverse decryption of a known vector, with keys the bench expands itself, cover them.

// File: rtl/aes_rnd_pkg.sv
package aes_rnd_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned NCOLS   = 4;
  localparam int unsigned NROWS   = 4;
  localparam int unsigned NBYTES  = NCOLS * NROWS;
  localparam int unsigned STATE_W = NBYTES * BYTE_W;
  localparam int unsigned OP_W    = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ENC      = 3'd0,
    OP_ENC_LAST = 3'd1,
    OP_DEC      = 3'd2,
    OP_DEC_LAST = 3'd3,
    OP_INV_MIX  = 3'd4
  } op_e;

  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc, p;
    acc = 8'h00;
    p   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ p;
      p = xtime(p);
    end
    return acc;
  endfunction

  // x^254 = x^-1 in GF(2^8), and 0 maps to 0
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] r, p;
    logic [7:0] e;
    r = 8'h01;
    p = a;
    e = 8'd254;
    for (int i = 0; i < 8; i++) begin
      if (e[i]) r = gf_mul(r, p);
      p = gf_mul(p, p);
    end
    return r;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] a, input int unsigned n);
    return (a << n) | (a >> (8 - n));
  endfunction

  function automatic logic [7:0] sbox_fwd(input logic [7:0] a);
    logic [7:0] b;
    b = gf_inv(a);
    return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
  endfunction

  function automatic logic [7:0] sbox_inv(input logic [7:0] a);
    return gf_inv(rotl8(a, 1) ^ rotl8(a, 3) ^ rotl8(a, 6) ^ 8'h05);
  endfunction

  // source byte index for row shift
  function automatic int unsigned shift_src(input bit inv, input int unsigned i);
    int unsigned off;
    off = NROWS * (i % NROWS);
    return inv ? (i + NBYTES - off) % NBYTES : (i + off) % NBYTES;
  endfunction

  function automatic logic [7:0] mix_coef(input bit inv, input int unsigned idx);
    case (idx % NROWS)
      0:       return inv ? 8'd14 : 8'd2;
      1:       return inv ? 8'd11 : 8'd3;
      2:       return inv ? 8'd13 : 8'd1;
      default: return inv ? 8'd9  : 8'd1;
    endcase
  endfunction
endpackage

// File: rtl/aes_rnd_shift.sv
module aes_rnd_shift
  import aes_rnd_pkg::*;
#(
  parameter bit INV = 1'b0
) (
  input  logic [STATE_W-1:0] din_i,
  output logic [STATE_W-1:0] dout_o
);
  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    localparam int unsigned SRC = shift_src(INV, i);
    assign dout_o[i*BYTE_W +: BYTE_W] = din_i[SRC*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/aes_rnd_sub.sv
module aes_rnd_sub
  import aes_rnd_pkg::*;
#(
  parameter bit INV = 1'b0
) (
  input  logic [STATE_W-1:0] din_i,
  output logic [STATE_W-1:0] dout_o
);
  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    if (INV) begin : g_inv
      assign dout_o[i*BYTE_W +: BYTE_W] = sbox_inv(din_i[i*BYTE_W +: BYTE_W]);
    end else begin : g_fwd
      assign dout_o[i*BYTE_W +: BYTE_W] = sbox_fwd(din_i[i*BYTE_W +: BYTE_W]);
    end
  end
endmodule

// File: rtl/aes_rnd_mix.sv
module aes_rnd_mix
  import aes_rnd_pkg::*;
#(
  parameter bit INV = 1'b0
) (
  input  logic [STATE_W-1:0] din_i,
  output logic [STATE_W-1:0] dout_o
);
  for (genvar c = 0; c < NCOLS; c++) begin : g_col
    for (genvar j = 0; j < NROWS; j++) begin : g_row
      logic [BYTE_W-1:0] acc;
      always_comb begin
        acc = '0;
        for (int k = 0; k < NROWS; k++) begin
          acc = acc ^ gf_mul(mix_coef(INV, (k + NROWS - j) % NROWS),
                             din_i[(c*NROWS + k)*BYTE_W +: BYTE_W]);
        end
      end
      assign dout_o[(c*NROWS + j)*BYTE_W +: BYTE_W] = acc;
    end
  end
endmodule

// File: rtl/aes_rnd_unit.sv
module aes_rnd_unit
  import aes_rnd_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [OP_W-1:0]     op_i,
  input  logic [STATE_W-1:0]  state_i,
  input  logic [STATE_W-1:0]  key_i,
  output logic                valid_o,
  output logic [STATE_W-1:0]  result_o
);
  logic [STATE_W-1:0] enc_sr, enc_sb, enc_mc;
  logic [STATE_W-1:0] dec_sr, dec_sb;
  logic [STATE_W-1:0] imix_in, imix_out;
  logic [STATE_W-1:0] res_d;
  op_e                op;

  assign op = op_e'(op_i);

  aes_rnd_shift #(.INV(1'b0)) u_shift_f (.din_i(state_i), .dout_o(enc_sr));
  aes_rnd_sub   #(.INV(1'b0)) u_sub_f   (.din_i(enc_sr),  .dout_o(enc_sb));
  aes_rnd_mix   #(.INV(1'b0)) u_mix_f   (.din_i(enc_sb),  .dout_o(enc_mc));

  aes_rnd_shift #(.INV(1'b1)) u_shift_i (.din_i(state_i), .dout_o(dec_sr));
  aes_rnd_sub   #(.INV(1'b1)) u_sub_i   (.din_i(dec_sr),  .dout_o(dec_sb));

  // one inverse mixer serves both the decrypt round and the key-prep op
  assign imix_in = (op == OP_INV_MIX) ? key_i : dec_sb;
  aes_rnd_mix   #(.INV(1'b1)) u_mix_i   (.din_i(imix_in), .dout_o(imix_out));

  always_comb begin
    case (op)
      OP_ENC:      res_d = enc_mc ^ key_i;
      OP_ENC_LAST: res_d = enc_sb ^ key_i;
      OP_DEC:      res_d = imix_out ^ key_i;
      OP_DEC_LAST: res_d = dec_sb ^ key_i;
      OP_INV_MIX:  res_d = imix_out;
      default:     res_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) result_o <= res_d;
    end
  end
endmodule

// File: rtl/aes_rnd_chk.sv
module aes_rnd_chk
  import aes_rnd_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               valid_i,
  input logic [OP_W-1:0]    op_i,
  input logic [STATE_W-1:0] key_i,
  input logic               valid_o,
  input logic [STATE_W-1:0] result_o
);
  a_r1_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  a_r1_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  a_r2_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o));

  a_r11_unused_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i > 3'd4) |=> (result_o == '0));

  a_r7_imc_zero_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd4 && key_i == '0) |=> (result_o == '0));

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r12_reset_clear: assert (!valid_o && result_o == '0);
    end
  end
endmodule

bind aes_rnd_unit aes_rnd_chk u_chk (.*);

// File: tb/aes_rnd_unit_tb.sv
module aes_rnd_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b1;
  logic         valid_i = 1'b0;
  logic [2:0]   op_i = 3'd0;
  logic [127:0] state_i = '0;
  logic [127:0] key_i = '0;
  logic         valid_o;
  logic [127:0] result_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] ref_sb [256];
  logic [127:0] rk [11];

  aes_rnd_unit u_dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [127:0] le(input logic [127:0] be);
    logic [127:0] r;
    for (int j = 0; j < 16; j++) r[8*j +: 8] = be[127-8*j -: 8];
    return r;
  endfunction

  function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
    logic [14:0] p;
    p = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (15'(a) << i);
    for (int i = 14; i >= 8; i--) if (p[i]) p = p ^ (15'h11b << (i - 8));
    return p[7:0];
  endfunction

  function automatic logic [127:0] fill(input logic [7:0] v);
    return {16{v}};
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic [2:0] op, input logic [127:0] s, input logic [127:0] k,
                       output logic [127:0] r);
    @(negedge clk_i);
    valid_i = 1'b1; op_i = op; state_i = s; key_i = k;
    @(negedge clk_i);
    r = result_o;
    chk("R1 valid_o after strobe", {127'd0, valid_o}, 128'd1);
    valid_i = 1'b0;
  endtask

  task automatic build_tables();
    for (int x = 0; x < 256; x++) begin
      logic [7:0] inv, b, o;
      inv = 8'h00;
      for (int y = 1; y < 256; y++) if (ref_mul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
      b = inv;
      for (int i = 0; i < 8; i++)
        o[i] = b[i] ^ b[(i+4)%8] ^ b[(i+5)%8] ^ b[(i+6)%8] ^ b[(i+7)%8] ^ ((8'h63 >> i) & 1'b1);
      ref_sb[x] = o;
    end
  endtask

  task automatic expand_key(input logic [127:0] key_le);
    logic [7:0] w [44][4];
    logic [7:0] rcon, t0;
    rcon = 8'h01;
    for (int i = 0; i < 4; i++) for (int b = 0; b < 4; b++) w[i][b] = key_le[8*(4*i+b) +: 8];
    for (int i = 4; i < 44; i++) begin
      logic [7:0] t [4];
      for (int b = 0; b < 4; b++) t[b] = w[i-1][b];
      if (i % 4 == 0) begin
        t0 = t[0];
        t[0] = ref_sb[t[1]] ^ rcon; t[1] = ref_sb[t[2]];
        t[2] = ref_sb[t[3]];        t[3] = ref_sb[t0];
        rcon = ref_mul(rcon, 8'h02);
      end
      for (int b = 0; b < 4; b++) w[i][b] = w[i-4][b] ^ t[b];
    end
    for (int r = 0; r < 11; r++)
      for (int i = 0; i < 4; i++) for (int b = 0; b < 4; b++) rk[r][8*(4*i+b) +: 8] = w[4*r+i][b];
  endtask

  task automatic t_reset();
    chk("R12 reset valid_o", {127'd0, valid_o}, 128'd0);
    chk("R12 reset result_o", result_o, 128'd0);
  endtask

  task automatic t_sbox_points();
    logic [127:0] r;
    do_op(3'd1, fill(8'h00), '0, r); chk("R9 fwd 00->63", r, fill(8'h63));
    do_op(3'd1, fill(8'h01), '0, r); chk("R9 fwd 01->7c", r, fill(8'h7c));
    do_op(3'd1, fill(8'h53), '0, r); chk("R9 fwd 53->ed", r, fill(8'hed));
    do_op(3'd3, fill(8'h63), '0, r); chk("R9 inv 63->00", r, fill(8'h00));
    do_op(3'd3, fill(8'h00), '0, r); chk("R9 inv 00->52", r, fill(8'h52));
  endtask

  task automatic t_sbox_sweep();
    logic [127:0] r1, r2;
    int bad_f = 0, bad_i = 0;
    for (int v = 0; v < 256; v++) begin
      do_op(3'd1, fill(8'(v)), '0, r1);
      if (r1 !== fill(ref_sb[v])) bad_f++;
      do_op(3'd3, r1, '0, r2);
      if (r2 !== fill(8'(v))) bad_i++;
    end
    chk("R9 fwd sweep mismatches", 128'(bad_f), 128'd0);
    chk("R9 inverse sweep mismatches", 128'(bad_i), 128'd0);
  endtask

  task automatic t_shift();
    logic [127:0] s, r, e;
    for (int i = 0; i < 16; i++) s[8*i +: 8] = 8'(i);
    do_op(3'd1, s, '0, r);
    for (int i = 0; i < 16; i++) e[8*i +: 8] = ref_sb[(i + 4*(i%4)) % 16];
    chk("R8 R4 forward shift order", r, e);
    for (int i = 0; i < 16; i++) s[8*i +: 8] = ref_sb[i];
    do_op(3'd3, s, '0, r);
    for (int i = 0; i < 16; i++) e[8*i +: 8] = 8'((i + 16 - 4*(i%4)) % 16);
    chk("R8 R6 inverse shift order", r, e);
  endtask

  task automatic t_imc();
    logic [127:0] r;
    do_op(3'd4, {128{1'b1}}, le(128'h8e4da1bc_8e4da1bc_8e4da1bc_8e4da1bc), r);
    chk("R7 R10 inv mix column", r, le(128'hdb135345_db135345_db135345_db135345));
    do_op(3'd4, '0, le(128'h8e4da1bc_8e4da1bc_8e4da1bc_8e4da1bc), r);
    chk("R7 state operand ignored", r, le(128'hdb135345_db135345_db135345_db135345));
  endtask

  task automatic t_round_pair();
    logic [127:0] s, r, m, d;
    s = le(128'h00102030405060708090a0b0c0d0e0f0);
    do_op(3'd0, s, le(128'hd6aa74fdd2af72fadaa678f1d6ab76fe), r);
    chk("R3 R10 one encrypt round", r, le(128'h89d810e8855ace682d1843d8cb128fe4));
    do_op(3'd0, s, '0, r);
    do_op(3'd4, 128'h5a5a, r, m);
    do_op(3'd3, m, '0, d);
    chk("R3 R7 R6 encrypt then undo", d, s);
    do_op(3'd1, s, 128'h1234, r);
    do_op(3'd3, r ^ 128'h1234, 128'hff00, d);
    chk("R4 R6 last-round key xor", d, s ^ 128'hff00);
  endtask

  task automatic t_full_block();
    logic [127:0] st, pt, dk;
    pt = le(128'h00112233445566778899aabbccddeeff);
    expand_key(le(128'h000102030405060708090a0b0c0d0e0f));
    st = pt ^ rk[0];
    for (int r = 1; r < 10; r++) do_op(3'd0, st, rk[r], st);
    do_op(3'd1, st, rk[10], st);
    chk("R3 R4 AES-128 ciphertext", st, le(128'h69c4e0d86a7b0430d8cdb78070b4c55a));
    st = st ^ rk[10];
    for (int r = 9; r >= 1; r--) begin
      do_op(3'd4, '0, rk[r], dk);
      do_op(3'd2, st, dk, st);
    end
    do_op(3'd3, st, rk[0], st);
    chk("R5 R6 R7 AES-128 decrypt", st, pt);
  endtask

  task automatic t_unused_and_idle();
    logic [127:0] r, held;
    for (int op = 5; op < 8; op++) begin
      do_op(3'(op), {128{1'b1}}, 128'h77, r);
      chk("R11 unused op zero", r, 128'd0);
    end
    do_op(3'd0, 128'h1, 128'h2, held);
    @(negedge clk_i);
    op_i = 3'd1; state_i = 128'hdead; key_i = 128'hbeef;
    @(negedge clk_i);
    chk("R1 valid_o low when idle", {127'd0, valid_o}, 128'd0);
    chk("R2 result held when idle", result_o, held);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    build_tables();
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_sbox_points();
    t_shift();
    t_imc();
    t_round_pair();
    t_full_block();
    t_unused_and_idle();
    t_sbox_sweep();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule